// File: doc/BRIEF.md
# Coherence Directory Home Controller

This block is the home-side directory engine of an invalidation-based cache coherence scheme. It keeps, for every line it is home to, three pieces of state: a pointer to the owner, which is the node that last held the line exclusively; a sharer bit vector with one bit per node; and one bit that says whether home itself holds an up-to-date copy. Requests reach the block on a valid/ready port. Each request is one of three kinds: a read, a read for exclusive ownership, or an upgrade from a node that already holds the line shared. The block answers each request with a sequence of messages on a second valid/ready port.

Home replies with data when its own copy is valid. Otherwise it forwards the request to the owner, which is trusted to service it. The directory entry is rewritten as the request is looked up, so no confirmation ever travels back to home and no request is refused or retried. Requests that arrive while the engine is busy wait in an arrival-ordered queue. After the primary message, the block sends one invalidation to each node that has to drop its copy. The first of these invalidations carries the total number of acknowledgements the requester must collect, and the node that acknowledges it hands that number on.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, and a sweep of one cycle per line, every line has its home copy valid, the owner pointer at node HOME_NODE and an empty sharer vector. The first read of any line from any node is then answered with a data reply from home, and out_valid stays low until a request arrives.
- R2: A read (in_kind 0) of a line whose home copy is valid produces a data reply (out_kind 0) addressed to the requester. If the home copy is not valid, it produces a forwarded read (out_kind 2) addressed to the owner, with out_req naming the requester.
- R3: A read sets the requester's sharer bit. When the read is forwarded, it also sets the owner's bit, so the dirty copy stays shared. The owner pointer does not change. The home copy stays invalid unless the parameter SHARE_WB is set.
- R4: A read-exclusive (in_kind 1) produces a data reply to the requester if the home copy is valid, and otherwise a forwarded read-exclusive (out_kind 3) to the owner. Afterwards the owner is the requester, the sharer vector is empty and the home copy is invalid.
- R5: An upgrade (in_kind 2) from a node whose sharer bit is set produces a grant without data (out_kind 1) to the requester. An upgrade from a node whose bit is clear is served exactly as a read-exclusive.
- R6: After the primary message, one invalidation (out_kind 4) goes to each node in the prior sharer vector, in ascending node order. The requester never receives one. When a read-exclusive was forwarded, the owner does not receive one either.
- R7: The first invalidation of a request carries in out_acks the number of invalidations sent for that request. Every other message carries zero.
- R8: Requests are served strictly in arrival order and none is lost. With the output stalled, in_ready stays high until DEPTH+1 requests have been accepted: DEPTH sit in the queue and one sits in the engine.
- R9: While out_valid is high and out_ready is low, every output field holds its value.
- R10: A read-exclusive from the current owner of a line whose home copy is invalid produces a grant without data (out_kind 1) to that owner, together with invalidations for the sharers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A request is offered |
| in_ready | output | 1 | The request queue has room |
| in_kind | input | 2 | 0 read, 1 read-exclusive, 2 upgrade |
| in_node | input | NW | Requesting node |
| in_line | input | LW | Line index |
| out_valid | output | 1 | An output message is offered |
| out_ready | input | 1 | The network takes the message |
| out_kind | output | 3 | 0 data, 1 grant, 2 fwd read, 3 fwd read-exclusive, 4 invalidate |
| out_dst | output | NW | Destination node |
| out_req | output | NW | Original requester |
| out_line | output | LW | Line index |
| out_acks | output | AW | Acknowledgement total (first invalidation only) |

## Verification
The assertions assume that no node sends a read for a line it already owns while the home copy is invalid, because such a request would be forwarded back to the node itself. The stimulus generator checks the bench's own copy of the directory before it issues a read. When the read would come from the owner of a line with an invalid home copy, the generator turns it into a read-exclusive, and that case is then used to exercise R10. The assertions also assume that the network never withdraws the message port's handshake in a way that breaks the valid/ready rules; the bench drives out_ready only one time unit after the clock edge. The sweep covers every line and node of a four-node, four-line configuration and mixes all three request kinds. It also throttles out_ready pseudo-randomly, so both stalls and queue build-up occur.

// File: rtl/dir_pkg.sv
package dir_pkg;
  localparam logic [1:0] REQ_RD  = 2'd0;
  localparam logic [1:0] REQ_RDX = 2'd1;
  localparam logic [1:0] REQ_UPG = 2'd2;

  localparam logic [2:0] MSG_DATA   = 3'd0;
  localparam logic [2:0] MSG_GRANT  = 3'd1;
  localparam logic [2:0] MSG_FWDRD  = 3'd2;
  localparam logic [2:0] MSG_FWDRDX = 3'd3;
  localparam logic [2:0] MSG_INV    = 3'd4;

  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_IDLE = 2'd1,
    ST_LOOK = 2'd2,
    ST_EMIT = 2'd3
  } eng_state_e;
endpackage

// File: rtl/dir_req_fifo.sv
module dir_req_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R8: the occupancy never exceeds the storage
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  // R8: a lone pop of the last entry leaves the queue empty
  a_r8_pop_last: assert property (@(posedge clk) disable iff (rst)
    (do_pop && !do_push && cnt == CW'(1)) |=> empty);
endmodule

// File: rtl/dir_table.sv
module dir_table #(
  parameter int LINES = 4,
  parameter int EW    = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic                     re,
  input  logic [$clog2(LINES)-1:0] addr,
  input  logic [EW-1:0]            wdata,
  output logic [EW-1:0]            rdata
);
  logic [EW-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/dir_decide.sv
module dir_decide import dir_pkg::*; #(
  parameter int NODES    = 4,
  parameter bit SHARE_WB = 1'b0,
  localparam int NW      = $clog2(NODES)
) (
  input  logic [1:0]       kind,
  input  logic [NW-1:0]    req,
  input  logic [NW-1:0]    owner,
  input  logic [NODES-1:0] sharers,
  input  logic             hv,
  output logic [2:0]       p_kind,
  output logic [NW-1:0]    p_dst,
  output logic [NW-1:0]    n_owner,
  output logic [NODES-1:0] n_sharers,
  output logic             n_hv,
  output logic [NODES-1:0] inv_set
);
  logic [NODES-1:0] req_bit, own_bit;
  logic             eff_excl;

  for (genvar g = 0; g < NODES; g++) begin : g_dec
    assign req_bit[g] = (req == NW'(g));
    assign own_bit[g] = (owner == NW'(g));
  end

  always_comb begin
    eff_excl  = (kind != REQ_RD);
    p_kind    = MSG_DATA;
    p_dst     = req;
    n_owner   = owner;
    n_sharers = sharers;
    n_hv      = hv;
    inv_set   = '0;
    if (!eff_excl) begin
      if (hv) begin
        p_kind    = MSG_DATA;
        p_dst     = req;
        n_sharers = sharers | req_bit;
      end else begin
        p_kind    = MSG_FWDRD;
        p_dst     = owner;
        n_sharers = sharers | req_bit | own_bit;
        n_hv      = SHARE_WB;
      end
    end else begin
      if (kind == REQ_UPG && |(sharers & req_bit)) begin
        p_kind  = MSG_GRANT;
        p_dst   = req;
        inv_set = sharers & ~req_bit;
      end else if (owner == req && !hv) begin
        p_kind  = MSG_GRANT;
        p_dst   = req;
        inv_set = sharers & ~req_bit;
      end else if (hv) begin
        p_kind  = MSG_DATA;
        p_dst   = req;
        inv_set = sharers & ~req_bit;
      end else begin
        p_kind  = MSG_FWDRDX;
        p_dst   = owner;
        inv_set = sharers & ~req_bit & ~own_bit;
      end
      n_owner   = req;
      n_sharers = '0;
      n_hv      = 1'b0;
    end
  end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl import dir_pkg::*; #(
  parameter int NODES     = 4,
  parameter int LINES     = 4,
  parameter int DEPTH     = 4,
  parameter int HOME_NODE = 0,
  parameter bit SHARE_WB  = 1'b0,
  localparam int NW       = $clog2(NODES),
  localparam int LW       = $clog2(LINES),
  localparam int AW       = $clog2(NODES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_kind,
  input  logic [NW-1:0] in_node,
  input  logic [LW-1:0] in_line,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [2:0]    out_kind,
  output logic [NW-1:0] out_dst,
  output logic [NW-1:0] out_req,
  output logic [LW-1:0] out_line,
  output logic [AW-1:0] out_acks
);
  localparam int QW = 2 + NW + LW;
  localparam int EW = 1 + NW + NODES;

  eng_state_e st;

  logic [QW-1:0] q_head;
  logic          q_empty, q_full, q_pop;
  logic [1:0]    h_kind;
  logic [NW-1:0] h_node;
  logic [LW-1:0] h_line;

  logic [LW-1:0] init_cnt;
  logic [1:0]    cur_kind;
  logic [NW-1:0] cur_req;
  logic [LW-1:0] cur_line;

  logic          t_we, t_re;
  logic [LW-1:0] t_addr;
  logic [EW-1:0] t_wdata, t_rdata;

  logic             rd_hv;
  logic [NW-1:0]    rd_owner;
  logic [NODES-1:0] rd_sharers;

  logic [2:0]       d_kind;
  logic [NW-1:0]    d_dst, d_owner;
  logic [NODES-1:0] d_sharers, d_inv;
  logic             d_hv;
  logic [AW-1:0]    d_cnt;

  logic [NODES-1:0] inv_pend;
  logic [AW-1:0]    inv_total;
  logic             inv_first;
  logic [NW-1:0]    pick;

  assign in_ready = !q_full;
  assign {h_kind, h_node, h_line} = q_head;
  assign q_pop = (st == ST_IDLE) && !q_empty;

  dir_req_fifo #(.W(QW), .DEPTH(DEPTH)) u_q (
    .clk   (clk),
    .rst   (rst),
    .push  (in_valid),
    .wdata ({in_kind, in_node, in_line}),
    .pop   (q_pop),
    .rdata (q_head),
    .empty (q_empty),
    .full  (q_full)
  );

  always_comb begin
    t_we    = (st == ST_INIT) || (st == ST_LOOK);
    t_re    = q_pop;
    t_addr  = h_line;
    t_wdata = {d_hv, d_owner, d_sharers};
    if (st == ST_INIT) begin
      t_addr  = init_cnt;
      t_wdata = {1'b1, NW'(HOME_NODE), {NODES{1'b0}}};
    end else if (st == ST_LOOK) begin
      t_addr  = cur_line;
    end
  end

  dir_table #(.LINES(LINES), .EW(EW)) u_tbl (
    .clk   (clk),
    .we    (t_we),
    .re    (t_re),
    .addr  (t_addr),
    .wdata (t_wdata),
    .rdata (t_rdata)
  );

  assign {rd_hv, rd_owner, rd_sharers} = t_rdata;

  dir_decide #(.NODES(NODES), .SHARE_WB(SHARE_WB)) u_dec (
    .kind      (cur_kind),
    .req       (cur_req),
    .owner     (rd_owner),
    .sharers   (rd_sharers),
    .hv        (rd_hv),
    .p_kind    (d_kind),
    .p_dst     (d_dst),
    .n_owner   (d_owner),
    .n_sharers (d_sharers),
    .n_hv      (d_hv),
    .inv_set   (d_inv)
  );

  always_comb begin
    d_cnt = '0;
    for (int i = 0; i < NODES; i++) d_cnt = d_cnt + AW'(d_inv[i]);
  end

  always_comb begin
    pick = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (inv_pend[i]) pick = NW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_INIT;
      init_cnt  <= '0;
      cur_kind  <= '0;
      cur_req   <= '0;
      cur_line  <= '0;
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_dst   <= '0;
      out_req   <= '0;
      out_line  <= '0;
      out_acks  <= '0;
      inv_pend  <= '0;
      inv_total <= '0;
      inv_first <= 1'b0;
    end else begin
      case (st)
        ST_INIT: begin
          init_cnt <= init_cnt + 1'b1;
          if (init_cnt == LW'(LINES - 1)) st <= ST_IDLE;
        end
        ST_IDLE: begin
          if (!q_empty) begin
            cur_kind <= h_kind;
            cur_req  <= h_node;
            cur_line <= h_line;
            st       <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          out_valid <= 1'b1;
          out_kind  <= d_kind;
          out_dst   <= d_dst;
          out_req   <= cur_req;
          out_line  <= cur_line;
          out_acks  <= '0;
          inv_pend  <= d_inv;
          inv_total <= d_cnt;
          inv_first <= 1'b1;
          st        <= ST_EMIT;
        end
        default: begin
          if (out_ready) begin
            if (|inv_pend) begin
              out_kind       <= MSG_INV;
              out_dst        <= pick;
              out_acks       <= inv_first ? inv_total : '0;
              inv_first      <= 1'b0;
              inv_pend[pick] <= 1'b0;
            end else begin
              out_valid <= 1'b0;
              st        <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end

  // R9: a stalled message holds every field
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) &&
      $stable(out_dst) && $stable(out_req) && $stable(out_line) && $stable(out_acks)));

  // R7: only invalidations carry an acknowledgement total
  a_r7_acks_inv_only: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind != MSG_INV) |-> (out_acks == '0));

  // R6: the requester is never invalidated
  a_r6_inv_not_req: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == MSG_INV) |-> (out_dst != out_req));

  // R5: an upgrade from a listed sharer gets a grant
  a_r5_upg_grant: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOOK && cur_kind == REQ_UPG && rd_sharers[cur_req]) |-> (d_kind == MSG_GRANT));

  // R4: an exclusive request leaves the requester as sole holder
  a_r4_excl_entry: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOOK && cur_kind != REQ_RD) |-> (d_owner == cur_req && d_sharers == '0 && !d_hv));
endmodule

// File: tb/sim_dir_home_ctrl.sv
module sim_dir_home_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NODES = 4;
  localparam int LINES = 4;
  localparam int DEPTH = 4;
  localparam int NW = 2;
  localparam int LW = 2;
  localparam int AW = 3;
  localparam int QMAX = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_kind = '0;
  logic [NW-1:0] in_node = '0;
  logic [LW-1:0] in_line = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [2:0] out_kind;
  logic [NW-1:0] out_dst, out_req;
  logic [LW-1:0] out_line;
  logic [AW-1:0] out_acks;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int produced = 0;
  int consumed = 0;
  bit hold_stall = 1'b0;
  bit finished = 1'b0;
  logic [31:0] seed = 32'h1234_5678;
  logic [31:0] rseed = 32'h0bad_cafe;

  int m_own [LINES];
  int m_sh  [LINES];
  int m_hv  [LINES];
  int ek [QMAX];
  int ed [QMAX];
  int er [QMAX];
  int el [QMAX];
  int ea [QMAX];

  always #(CLK_PERIOD/2) clk = ~clk;

  dir_home_ctrl #(.NODES(NODES), .LINES(LINES), .DEPTH(DEPTH), .HOME_NODE(0), .SHARE_WB(1'b0)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_node(in_node), .in_line(in_line),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_dst(out_dst), .out_req(out_req), .out_line(out_line), .out_acks(out_acks)
  );

  function automatic logic [31:0] lcg(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  task automatic expect_msg(input int k, input int d, input int r, input int l, input int a);
    ek[produced] = k; ed[produced] = d; er[produced] = r; el[produced] = l; ea[produced] = a;
    produced++;
  endtask

  // bench directory model, written from R2-R7 and R10
  task automatic model(input int k, input int n, input int l);
    int eff, inv, cnt, first;
    eff = k;
    if (k == 2 && ((m_sh[l] >> n) & 1) == 0) eff = 1;
    if (eff == 0) begin
      if (m_hv[l] != 0) expect_msg(0, n, n, l, 0);
      else expect_msg(2, m_own[l], n, l, 0);
      m_sh[l] = m_sh[l] | (1 << n) | ((m_hv[l] != 0) ? 0 : (1 << m_own[l]));
    end else begin
      if (eff == 2) begin
        expect_msg(1, n, n, l, 0); inv = m_sh[l] & ~(1 << n);
      end else if (m_own[l] == n && m_hv[l] == 0) begin
        expect_msg(1, n, n, l, 0); inv = m_sh[l] & ~(1 << n);
      end else if (m_hv[l] != 0) begin
        expect_msg(0, n, n, l, 0); inv = m_sh[l] & ~(1 << n);
      end else begin
        expect_msg(3, m_own[l], n, l, 0); inv = m_sh[l] & ~(1 << n) & ~(1 << m_own[l]);
      end
      cnt = 0;
      for (int i = 0; i < NODES; i++) if ((inv >> i) & 1) cnt++;
      first = 1;
      for (int i = 0; i < NODES; i++) begin
        if ((inv >> i) & 1) begin
          expect_msg(4, i, n, l, first ? cnt : 0);
          first = 0;
        end
      end
      m_own[l] = n; m_sh[l] = 0; m_hv[l] = 0;
    end
  endtask

  // keep within the input rule: no read from the owner of a line held dirty
  function automatic int legal_kind(input int k, input int n, input int l);
    if (k == 0 && m_hv[l] == 0 && m_own[l] == n) return 1;
    return k;
  endfunction

  task automatic push(input int k, input int n, input int l);
    int kk;
    kk = legal_kind(k, n, l);
    @(negedge clk);
    in_valid = 1'b1; in_kind = 2'(kk); in_node = NW'(n); in_line = LW'(l);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    model(kk, n, l);
    #1 in_valid = 1'b0;
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_drain();
    int t;
    t = 0;
    while (consumed < produced && t < 20000) begin
      @(negedge clk); t++;
    end
    repeat (3) @(negedge clk);
  endtask

  // output handshake driver
  always @(posedge clk) begin
    #1;
    rseed = lcg(rseed);
    out_ready = hold_stall ? 1'b0 : (rseed[17:16] != 2'b00);
  end

  // monitor: compare each accepted message against the model queue (R2-R7, R10)
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (consumed >= produced) begin
        check("R8 unexpected message", 1, 0);
      end else begin
        total++;
        if (out_kind != 3'(ek[consumed]) || out_dst != NW'(ed[consumed]) ||
            out_req != NW'(er[consumed]) || out_line != LW'(el[consumed]) ||
            out_acks != AW'(ea[consumed])) begin
          bad++;
          $display("FAIL R2-R7/R10 msg %0d actual kind=%0d dst=%0d req=%0d line=%0d acks=%0d expected kind=%0d dst=%0d req=%0d line=%0d acks=%0d",
            consumed, out_kind, out_dst, out_req, out_line, out_acks,
            ek[consumed], ed[consumed], er[consumed], el[consumed], ea[consumed]);
        end
      end
      consumed++;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int acc, k, n, l;
    for (int i = 0; i < LINES; i++) begin
      m_own[i] = 0; m_sh[i] = 0; m_hv[i] = 1;
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 in_ready after reset", int'(in_ready), 1);

    // R1/R2: first read of every line gets data from home
    for (int i = 0; i < LINES; i++) push(0, 1 + (i % 3), i);
    wait_drain();
    check("R1 first reads answered", consumed, produced);

    // R3/R4/R6/R7/R10: directed chain on line 0
    push(0, 2, 0);      // second sharer
    push(1, 3, 0);      // data from home, invalidate 1 and 2
    push(0, 1, 0);      // forwarded read to owner 3
    push(2, 1, 0);      // R5 upgrade from sharer: grant, invalidate 3
    push(2, 2, 0);      // R5 upgrade from non-sharer: read-exclusive, forward to 1
    push(0, 2, 0);      // R10: read by owner becomes read-exclusive -> grant
    wait_drain();
    check("R6 directed chain drained", consumed, produced);

    // R8: fill the queue with the output stalled
    hold_stall = 1'b1;
    repeat (3) @(negedge clk);
    acc = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      k = legal_kind(0, 1 + (i % 3), i % LINES);
      in_valid = 1'b1; in_kind = 2'(k); in_node = NW'(1 + (i % 3)); in_line = LW'(i % LINES);
      if (!in_ready) break;
      @(posedge clk);
      model(k, 1 + (i % 3), i % LINES);
      acc++;
    end
    in_valid = 1'b0;
    check("R8 accepted while stalled", acc, DEPTH + 1);
    check("R8 in_ready low when full", int'(in_ready), 0);
    check("R9 message still offered", int'(out_valid), 1);
    hold_stall = 1'b0;
    wait_drain();
    check("R8 all queued requests served", consumed, produced);

    // sweep: every kind, node and line under random stalls
    for (int i = 0; i < 1500; i++) begin
      seed = lcg(seed);
      k = int'(seed[21:20]) % 3;
      n = int'(seed[25:24]);
      l = int'(seed[29:28]);
      push(k, n, l);
    end
    wait_drain();
    check("R8 sweep order and count", consumed, produced);
    check("R9 idle after drain", int'(out_valid), 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule